// File: doc/BRIEF.md
# Calendar Flow-Control Status Receiver

This block sits on the receive side of a flow-control status channel. Each cycle it takes one 2-bit status word, finds frame boundaries from the framing code, and walks a programmable calendar of slots. The word in slot k is the flow-control state of logical port k. A 2-bit diagonal parity word closes every frame and is checked against a running parity. The block keeps a synchronization state and drives a packed per-port status vector to the transmit scheduler. It also raises one-cycle events for parity errors and for loss of synchronization.

The block can be set to expect a calendar selection word straight after the framing word. The upper bit of that word picks one of two calendars, which differ in length. A coverage option sets whether the selection word enters the parity. In a mode with no status channel, the received stream is ignored and every port reads as starving. All configuration is given as static inputs.

Top module: `cal_stat_rx`

## Requirements
- R1: Status codes are 00 starving, 01 hungry, 10 satisfied and 11 framing. A frame is a 11 word, then the selection word if selection is enabled, then one word per calendar slot, then the parity word. The word in slot k belongs to port k, and `port_stat_o[2k+1:2k]` carries port k.
- R2: The parity starts at 00 after the framing word. Each covered word w updates the accumulator a to {a[0]^w[1], a[1]^w[0]}. With selection disabled, only the slot words are covered. The parity word must equal the final accumulator.
- R3: With selection enabled, the selection word is covered by the parity when `dip_csw_i` is 1 and excluded when it is 0.
- R4: While in sync, a port's status changes in the cycle after its slot word is sampled, and ports whose slots come later keep their old value until then.
- R5: A parity mismatch while in sync gives a one-cycle `dip_err_o` pulse, and every port reads satisfied in the same cycle. A mismatch while out of sync gives no pulse.
- R6: While out of sync, every port reads satisfied.
- R7: Sync is declared after `good_thr_i` consecutive frames that have a framing word and a correct parity.
- R8: While in sync, `bad_thr_i` consecutive bad frames clear `in_sync_o` and give a one-cycle `sync_lost_o` pulse.
- R9: A non-11 word where the framing word is due counts as a bad frame, raises no `dip_err_o`, and makes the receiver hunt for the next 11 word.
- R10: With selection enabled, selection bit 1 picks calendar 1 (`cal_len1_i` slots) and bit 0 picks calendar 0 (`cal_len0_i` slots). Its value is captured into `cal_id_o` only while in sync. With selection disabled, every frame uses calendar 0.
- R11: With `no_stat_i` set, the stream is ignored, `in_sync_o` is 0, no events are raised, and every port reads starving.
- R12: After reset, `in_sync_o`, `dip_err_o`, `sync_lost_o` and `cal_id_o` are 0 and every port reads satisfied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Status channel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_i | input | 2 | Received status word |
| no_stat_i | input | 1 | No status channel mode |
| csw_en_i | input | 1 | Expect a calendar selection word |
| dip_csw_i | input | 1 | Include the selection word in the parity |
| cal_len0_i | input | LEN_W | Slot count of calendar 0 |
| cal_len1_i | input | LEN_W | Slot count of calendar 1 |
| good_thr_i | input | THR_W | Good frames needed to gain sync |
| bad_thr_i | input | THR_W | Bad frames needed to lose sync |
| port_stat_o | output | 2*NUM_PORTS | Packed per-port status |
| in_sync_o | output | 1 | Synchronization state |
| dip_err_o | output | 1 | Parity error event |
| sync_lost_o | output | 1 | Sync loss event |
| cal_id_o | output | 1 | Active calendar identifier |

## Verification
The bound checker tests the following on every cycle:
- every port reads starving, and sync stays cleared, after a cycle in no-status mode;
- every port reads satisfied after any out-of-sync cycle and alongside every parity error pulse;
- a parity error pulse only follows a cycle spent in sync;
- a sync-loss pulse coincides with a falling sync state;
- the calendar identifier holds while out of sync or while selection is off.

The rest can only be shown by the bench's scenarios:
- that the parity arithmetic and the selection-word coverage are right;
- that slots map to ports one by one and each updates in its own cycle;
- that the good and bad frame thresholds are counted correctly;
- that a missing framing word is handled correctly;
- that the right calendar length is chosen.

// File: rtl/cal_stat_pkg.sv
package cal_stat_pkg;
  typedef enum logic [1:0] {
    ST_STARVE = 2'b00,
    ST_HUNGRY = 2'b01,
    ST_SAT    = 2'b10,
    ST_FRAME  = 2'b11
  } stat_e;

  typedef enum logic [2:0] {
    F_HUNT, F_SEL, F_SLOT, F_DIP, F_FRM
  } fstate_e;

  // diagonal parity: rotate the accumulator and fold in the new word
  function automatic logic [1:0] dip_step(input logic [1:0] acc, input logic [1:0] w);
    return {acc[0] ^ w[1], acc[1] ^ w[0]};
  endfunction
endpackage

// File: rtl/cal_stat_sync.sv
module cal_stat_sync #(
  parameter int THR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             no_stat_i,
  input  logic             frm_good_i,
  input  logic             frm_bad_i,
  input  logic [THR_W-1:0] good_thr_i,
  input  logic [THR_W-1:0] bad_thr_i,
  output logic             in_sync_o,
  output logic             sync_lost_o
);
  logic [THR_W-1:0] cnt_q;
  logic [THR_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sync_o   <= 1'b0;
      sync_lost_o <= 1'b0;
      cnt_q       <= '0;
    end else begin
      sync_lost_o <= 1'b0;
      if (no_stat_i) begin
        in_sync_o <= 1'b0;
        cnt_q     <= '0;
      end else if (!in_sync_o) begin
        if (frm_bad_i) cnt_q <= '0;
        else if (frm_good_i) begin
          if (cnt_inc >= {1'b0, good_thr_i}) begin
            in_sync_o <= 1'b1;
            cnt_q     <= '0;
          end else cnt_q <= cnt_inc[THR_W-1:0];
        end
      end else begin
        if (frm_good_i) cnt_q <= '0;
        else if (frm_bad_i) begin
          if (cnt_inc >= {1'b0, bad_thr_i}) begin
            in_sync_o   <= 1'b0;
            sync_lost_o <= 1'b1;
            cnt_q       <= '0;
          end else cnt_q <= cnt_inc[THR_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/cal_stat_ports.sv
module cal_stat_ports
  import cal_stat_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   no_stat_i,
  input  logic                   in_sync_i,
  input  logic                   force_sat_i,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [1:0]             wr_val_i,
  output logic [2*NUM_PORTS-1:0] port_stat_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   port_stat_o[2*p +: 2] <= ST_SAT;
      else if (no_stat_i)                            port_stat_o[2*p +: 2] <= ST_STARVE;
      else if (!in_sync_i || force_sat_i)            port_stat_o[2*p +: 2] <= ST_SAT;
      else if (wr_en_i && wr_idx_i == IDX_W'(p))     port_stat_o[2*p +: 2] <= wr_val_i;
    end
  end
endmodule

// File: rtl/cal_stat_rx.sv
module cal_stat_rx
  import cal_stat_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int THR_W     = 4,
  localparam int LEN_W    = $clog2(NUM_PORTS + 1),
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             stat_i,
  input  logic                   no_stat_i,
  input  logic                   csw_en_i,
  input  logic                   dip_csw_i,
  input  logic [LEN_W-1:0]       cal_len0_i,
  input  logic [LEN_W-1:0]       cal_len1_i,
  input  logic [THR_W-1:0]       good_thr_i,
  input  logic [THR_W-1:0]       bad_thr_i,
  output logic [2*NUM_PORTS-1:0] port_stat_o,
  output logic                   in_sync_o,
  output logic                   dip_err_o,
  output logic                   sync_lost_o,
  output logic                   cal_id_o
);
  fstate_e          st_q, st_d;
  logic [1:0]       acc_q, acc_d;
  logic [LEN_W-1:0] slot_q, slot_d, len_q, len_d;
  logic [LEN_W:0]   slot_inc;
  logic             wr_en, frm_good, frm_bad, dip_bad, is_frame;
  logic             cal_id_q;

  assign is_frame = (stat_i == ST_FRAME);
  assign slot_inc = {1'b0, slot_q} + 1'b1;

  always_comb begin
    st_d     = st_q;
    acc_d    = acc_q;
    slot_d   = slot_q;
    len_d    = len_q;
    wr_en    = 1'b0;
    frm_good = 1'b0;
    frm_bad  = 1'b0;
    dip_bad  = 1'b0;
    unique case (st_q)
      F_HUNT, F_FRM: begin
        if (is_frame) begin
          acc_d  = 2'b00;
          slot_d = '0;
          len_d  = cal_len0_i;
          st_d   = csw_en_i ? F_SEL : F_SLOT;
        end else if (st_q == F_FRM) begin
          frm_bad = 1'b1;           // framing word missing
          st_d    = F_HUNT;
        end
      end
      F_SEL: begin
        len_d = stat_i[1] ? cal_len1_i : cal_len0_i;
        acc_d = dip_csw_i ? dip_step(2'b00, stat_i) : 2'b00;
        st_d  = F_SLOT;
      end
      F_SLOT: begin
        acc_d  = dip_step(acc_q, stat_i);
        wr_en  = (slot_q < LEN_W'(NUM_PORTS));
        slot_d = slot_inc[LEN_W-1:0];
        if (slot_inc >= {1'b0, len_q}) st_d = F_DIP;
      end
      F_DIP: begin
        if (stat_i == acc_q) frm_good = 1'b1;
        else begin
          frm_bad = 1'b1;
          dip_bad = 1'b1;
        end
        st_d = F_FRM;
      end
      default: st_d = F_HUNT;
    endcase
    if (no_stat_i) begin
      st_d     = F_HUNT;
      wr_en    = 1'b0;
      frm_good = 1'b0;
      frm_bad  = 1'b0;
      dip_bad  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= F_HUNT;
      acc_q     <= 2'b00;
      slot_q    <= '0;
      len_q     <= '0;
      dip_err_o <= 1'b0;
      cal_id_q  <= 1'b0;
    end else begin
      st_q      <= st_d;
      acc_q     <= acc_d;
      slot_q    <= slot_d;
      len_q     <= len_d;
      dip_err_o <= dip_bad && in_sync_o;
      if (st_q == F_SEL && in_sync_o && csw_en_i && !no_stat_i) cal_id_q <= stat_i[1];
    end
  end

  assign cal_id_o = cal_id_q;

  cal_stat_sync #(.THR_W(THR_W)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .no_stat_i  (no_stat_i),
    .frm_good_i (frm_good),
    .frm_bad_i  (frm_bad),
    .good_thr_i (good_thr_i),
    .bad_thr_i  (bad_thr_i),
    .in_sync_o  (in_sync_o),
    .sync_lost_o(sync_lost_o)
  );

  cal_stat_ports #(.NUM_PORTS(NUM_PORTS)) u_ports (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .no_stat_i  (no_stat_i),
    .in_sync_i  (in_sync_o),
    .force_sat_i(dip_bad && in_sync_o),
    .wr_en_i    (wr_en),
    .wr_idx_i   (slot_q[IDX_W-1:0]),
    .wr_val_i   (stat_i),
    .port_stat_o(port_stat_o)
  );
endmodule

// File: rtl/cal_stat_rx_chk.sv
module cal_stat_rx_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   no_stat_i,
  input logic                   csw_en_i,
  input logic [2*NUM_PORTS-1:0] port_stat_o,
  input logic                   in_sync_o,
  input logic                   dip_err_o,
  input logic                   sync_lost_o,
  input logic                   cal_id_o
);
  localparam logic [2*NUM_PORTS-1:0] ALL_SAT = {NUM_PORTS{2'b10}};

  p_nostat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(no_stat_i) |-> (!in_sync_o && port_stat_o == '0 && !dip_err_o && !sync_lost_o));

  p_oos_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!in_sync_o && !no_stat_i) |-> port_stat_o == ALL_SAT);

  p_dip_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dip_err_o |-> (port_stat_o == ALL_SAT && $past(in_sync_o)));

  p_lost_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_lost_o |-> (!in_sync_o && $past(in_sync_o)));

  p_calid_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(in_sync_o) || !$past(csw_en_i)) |-> $stable(cal_id_o));
endmodule

bind cal_stat_rx cal_stat_rx_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/sim_cal_stat_rx.sv
`timescale 1ns/1ps
module sim_cal_stat_rx;
  localparam int NP = 4;
  localparam int LW = $clog2(NP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    stat = 2'b00;
  logic          no_stat = 1'b0, csw_en = 1'b0, dip_csw = 1'b0;
  logic [LW-1:0] len0 = 3, len1 = 4;
  logic [3:0]    gthr = 2, bthr = 2;
  logic [2*NP-1:0] port_stat;
  logic          in_sync, dip_err, sync_lost, cal_id;

  int checks = 0, fails = 0;
  logic [2*NP-1:0] model = 8'hAA;

  always #2.5 clk = ~clk;

  cal_stat_rx #(.NUM_PORTS(NP), .THR_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .stat_i(stat), .no_stat_i(no_stat),
    .csw_en_i(csw_en), .dip_csw_i(dip_csw), .cal_len0_i(len0), .cal_len1_i(len1),
    .good_thr_i(gthr), .bad_thr_i(bthr), .port_stat_o(port_stat),
    .in_sync_o(in_sync), .dip_err_o(dip_err), .sync_lost_o(sync_lost), .cal_id_o(cal_id));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] pstep(input logic [1:0] a, input logic [1:0] w);
    return {a[0] ^ w[1], a[1] ^ w[0]};
  endfunction

  task automatic word(input logic [1:0] w);
    stat = w;
    @(posedge clk);
    #1;
  endtask

  // mode: 0 correct parity, 1 corrupted parity, 2 wrong selection-word coverage
  task automatic send_frame(input logic [1:0] sel, input logic [7:0] vals, input int mode);
    int n;
    logic [1:0] acc;
    logic sb;
    logic [7:0] prev;
    sb   = in_sync;
    prev = port_stat;
    n    = (csw_en && sel[1]) ? int'(len1) : int'(len0);
    acc  = 2'b00;
    word(2'b11);
    if (csw_en) begin
      word(sel);
      if (dip_csw ^ (mode == 2)) acc = pstep(acc, sel);
    end
    for (int k = 0; k < n; k++) begin
      word(vals[2*k +: 2]);
      acc = pstep(acc, vals[2*k +: 2]);
      if (sb && !no_stat && k == 0) begin
        chk("R4 slot0 updated", port_stat[1:0], vals[1:0]);
        if (n > 1) chk("R4 slot1 not yet", port_stat[3:2], prev[3:2]);
      end
    end
    if (mode == 1) acc ^= 2'b01;
    word(acc);
    if (!no_stat) begin
      if (!sb || mode != 0) model = 8'hAA;
      else for (int k = 0; k < n; k++) model[2*k +: 2] = vals[2*k +: 2];
      chk("R5 dip_err", dip_err, sb && mode != 0);
      chk("R1 R6 port status", port_stat, model);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    chk("R12 ports", port_stat, 8'hAA);
    chk("R12 in_sync", in_sync, 0);
    chk("R12 dip_err", dip_err, 0);
    chk("R12 sync_lost", sync_lost, 0);
    chk("R12 cal_id", cal_id, 0);

    // R11 no-status mode ignores well-formed frames
    no_stat = 1'b1;
    word(2'b00);
    for (int i = 0; i < 3; i++) send_frame(2'b00, 8'h15, 0);
    chk("R11 starving", port_stat, 8'h00);
    chk("R11 no sync", in_sync, 0);
    chk("R11 no event", dip_err | sync_lost, 0);
    no_stat = 1'b0;
    word(2'b00);
    chk("R6 back to satisfied", port_stat, 8'hAA);

    // R7 acquisition with threshold 2
    send_frame(2'b00, 8'h04, 0);
    chk("R7 one good frame", in_sync, 0);
    send_frame(2'b00, 8'h04, 0);
    chk("R7 two good frames", in_sync, 1);

    // R1 R2 R4 sweep over all status values on three slots
    for (int v = 0; v < 27; v++) begin
      logic [7:0] vals;
      vals = {2'b00, 2'(v / 9), 2'((v / 3) % 3), 2'(v % 3)};
      send_frame(2'b00, vals, 0);
      chk("R2 stays in sync", in_sync, 1);
      chk("R1 port3 outside calendar", port_stat[7:6], 2'b10);
    end

    // R5 single error keeps sync, R8 two consecutive lose it
    send_frame(2'b00, 8'h01, 1);
    chk("R5 still in sync", in_sync, 1);
    word(2'b11);
    chk("R5 pulse one cycle", dip_err, 0);
    word(2'b00);                      // selects nothing: slot 0 of a frame
    word(2'b00); word(2'b00);
    word(2'b00);                      // parity of 00,00,00 is 00
    chk("R8 good resets count", in_sync, 1);
    send_frame(2'b00, 8'h12, 1);
    chk("R8 first bad", sync_lost, 0);
    send_frame(2'b00, 8'h12, 1);
    chk("R8 lost pulse", sync_lost, 1);
    chk("R8 in_sync cleared", in_sync, 0);
    send_frame(2'b00, 8'h11, 1);
    chk("R5 no event out of sync", dip_err, 0);
    chk("R8 pulse one cycle", sync_lost, 0);

    // R9 missing framing
    send_frame(2'b00, 8'h00, 0);
    send_frame(2'b00, 8'h00, 0);
    chk("R7 reacquired", in_sync, 1);
    word(2'b01);
    chk("R9 no dip_err", dip_err, 0);
    chk("R9 still in sync", in_sync, 1);
    word(2'b00);                      // hunting: ignored
    send_frame(2'b00, 8'h15, 1);
    chk("R9 R8 missing frame counted", sync_lost, 1);
    chk("R9 sync lost", in_sync, 0);

    // R10 R3 two calendars, selection covered
    csw_en = 1'b1; dip_csw = 1'b1;
    send_frame(2'b10, 8'h00, 0);
    chk("R10 id held out of sync", cal_id, 0);
    send_frame(2'b10, 8'h00, 0);
    chk("R10 synced", in_sync, 1);
    chk("R10 id held at sync edge", cal_id, 0);
    send_frame(2'b10, 8'h64, 0);
    chk("R10 id from calendar 1", cal_id, 1);
    chk("R10 port3 via calendar 1", port_stat[7:6], 2'b01);
    send_frame(2'b00, 8'h00, 0);
    chk("R10 id from calendar 0", cal_id, 0);
    chk("R10 port3 untouched", port_stat[7:6], 2'b01);
    send_frame(2'b10, 8'h15, 2);
    chk("R3 excluded selection is error", in_sync, 1);
    send_frame(2'b10, 8'h15, 0);
    dip_csw = 1'b0;
    send_frame(2'b10, 8'h26, 0);
    chk("R3 uncovered good", dip_err, 0);
    send_frame(2'b10, 8'h26, 2);
    chk("R3 covered when off is error", dip_err, 1);
    send_frame(2'b00, 8'h05, 0);
    chk("R3 final sync", in_sync, 1);

    // R10 selection off keeps id
    csw_en = 1'b0;
    send_frame(2'b00, 8'h2A, 0);
    chk("R10 id held when disabled", cal_id, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule